// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog timer with a simple 32-bit register bus. Software sets a 16-bit reload value and enables the timer. After that, an internal down-counter steps once for each pulse on the `tick` input. A prescaler outside the block supplies that pulse. Software must reload the counter before it runs out, either by writing the kick register or by enabling the timer. If it does not, the block takes one of two expiry actions.

In reset mode, expiry drives a single-cycle pulse on the chip-reset output, and the block then returns to its power-on state. In interrupt mode, expiry does four things: it clears the mode bit itself, sets an event flag, raises the interrupt if the interrupt is enabled, and reloads the counter. Because the mode bit clears itself, a missed first deadline gives software one interrupt to recover, and a second missed deadline resets the chip.

Three stall sources can each freeze counting while their input is high, provided their enable bit is set: a hibernation timer, a week timer and an active debug session.

Top module: `wdog_twostage`

## Requirements
- R1: After reset the register reads are: reload (0x00) = 0xFFFF, control (0x04) = 0, count (0x0C) = 0xFFFF, event status (0x10) = 0, interrupt enable (0x14) = 0. `irq` and `chip_rst` are low.
- R2: The control register keeps only the bits in mask 0x021D, and all other bits read as zero. Control bit 0 is enable, bits 2/3/4 are the stall enables for the hibernation, week and debug stall inputs, and bit 9 is the mode (1 = interrupt). The reload register keeps write-data bits 15:0. A write to the count register at 0x0C has no effect.
- R3: A write that changes control bit 0 from 0 to 1 copies the reload value into the counter. While the timer is enabled and not stalled, each cycle with `tick` high lowers the count by one.
- R4: While control bit 0 is 0, the count does not change on ticks, and no expiry action occurs.
- R5: Stall input k (k = 0 hibernation, 1 week, 2 debug) holds the count only while control bit 2+k is also set. A stall input whose enable bit is clear has no effect.
- R6: A write of any data to the kick register at 0x08 copies the reload value into the counter.
- R7: Expiry is a counted tick while the count is 1 or 0. In reset mode (control bit 9 = 0), `chip_rst` goes high for exactly one cycle, in the cycle after the expiry tick. In the cycle after that, every register holds its R1 value.
- R8: On expiry in interrupt mode, control bit 9 clears, status bit 0 sets and the counter reloads. `chip_rst` stays low.
- R9: `irq` is high exactly when status bit 0 and interrupt-enable bit 0 are both 1. Writing 1 to status bit 0 clears it.
- R10: A kick in the same cycle as an expiry tick reloads the counter, and no expiry action occurs.
- R11: Starting from interrupt mode with no kicks, the first expiry gives an interrupt and no reset, and the second expiry gives the reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | ADDR_W (8) | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| tick | input | 1 | Count tick from an external prescaler |
| stall_hib | input | 1 | Hibernation-timer stall request |
| stall_week | input | 1 | Week-timer stall request |
| stall_dbg | input | 1 | Debug-session stall request |
| irq | output | 1 | Watchdog event interrupt |
| chip_rst | output | 1 | Single-cycle chip-reset pulse |

## Verification
The bound checker watches, on every cycle, the properties of the counter that depend on a single cycle: the one-cycle reset pulse and the state restored after it, the step of one per counted tick, the hold while disabled or stalled, the reload on every kick, and the interrupt-mode expiry clearing the mode bit and setting the event flag. The bench scenarios are needed for the behaviour that unfolds over many cycles. These are the two-stage sequence from interrupt to reset, the masking and write-one-to-clear of the interrupt, the control bits that cannot be written, the ignored count writes, and the order of priority when a kick meets an expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W     = 16;
  localparam int NUM_STALL = 3;

  // register byte offsets
  localparam int OFS_LOAD = 'h00;
  localparam int OFS_CTRL = 'h04;
  localparam int OFS_KICK = 'h08;
  localparam int OFS_CNT  = 'h0C;
  localparam int OFS_STS  = 'h10;
  localparam int OFS_IEN  = 'h14;

  // control field positions
  localparam int CB_EN     = 0;
  localparam int CB_STALL0 = 2;
  localparam int CB_MODE   = 9;
  localparam logic [31:0] CTRL_MASK = 32'h0000_021D;

  localparam logic [CNT_W-1:0] LOAD_RST = '1;
endpackage

// File: rtl/wdog_stall.sv
module wdog_stall #(
  parameter int N = 3
) (
  input  logic [N-1:0] stall_in,
  input  logic [N-1:0] stall_en,
  output logic         stalled
);
  logic [N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_src
    assign hit[i] = stall_in[i] & stall_en[i];
  end

  assign stalled = |hit;
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int               CNT_W   = 16,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             go,
  input  logic             tick,
  input  logic             ld_req,
  input  logic             mode_irq,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step;

  always_comb begin
    step   = go & tick;
    expire = step & (cnt_q <= CNT_W'(1)) & ~ld_req & ~soft_rst;
    cnt_d  = cnt_q;
    if (soft_rst)              cnt_d = RST_VAL;
    else if (ld_req)           cnt_d = ld_val;
    else if (expire & mode_irq) cnt_d = ld_val;
    else if (step)             cnt_d = (cnt_q != '0) ? cnt_q - CNT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              wr_load,
  input  logic              wr_ctrl,
  input  logic              wr_sts,
  input  logic              wr_ien,
  input  logic [DATA_W-1:0] wdata,
  input  logic              exp_irq,
  output logic [CNT_W-1:0]  load_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              sts_q,
  output logic              ien_q
);
  import wdog_pkg::*;

  logic [CNT_W-1:0]  load_d;
  logic [DATA_W-1:0] ctrl_d;
  logic              sts_d, ien_d;

  always_comb begin
    load_d = load_q;
    ctrl_d = ctrl_q;
    sts_d  = sts_q;
    ien_d  = ien_q;
    if (wr_load) load_d = wdata[CNT_W-1:0];
    if (wr_ctrl) ctrl_d = wdata & DATA_W'(CTRL_MASK);
    if (wr_ien)  ien_d  = wdata[0];
    if (wr_sts && wdata[0]) sts_d = 1'b0;
    if (exp_irq) begin
      ctrl_d[CB_MODE] = 1'b0;
      sts_d           = 1'b1;
    end
    if (soft_rst) begin
      load_d = LOAD_RST;
      ctrl_d = '0;
      sts_d  = 1'b0;
      ien_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= LOAD_RST;
      ctrl_q <= '0;
      sts_q  <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      load_q <= load_d;
      ctrl_q <= ctrl_d;
      sts_q  <= sts_d;
      ien_q  <= ien_d;
    end
  end
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick,
  input  logic              stall_hib,
  input  logic              stall_week,
  input  logic              stall_dbg,
  output logic              irq,
  output logic              chip_rst
);
  import wdog_pkg::*;

  logic [1:0]        rst_sync;
  logic              rst_i_n;
  logic [CNT_W-1:0]  load_q, cnt;
  logic [DATA_W-1:0] ctrl_q;
  logic              sts_q, ien_q;
  logic              wr_load, wr_ctrl, wr_kick, wr_sts, wr_ien;
  logic              en_rise, ld_req, stalled, go, expire, exp_irq;
  logic              pulse_q, pulse_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  always_comb begin
    wr_load = bus_we && (bus_addr == ADDR_W'(OFS_LOAD));
    wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
    wr_kick = bus_we && (bus_addr == ADDR_W'(OFS_KICK));
    wr_sts  = bus_we && (bus_addr == ADDR_W'(OFS_STS));
    wr_ien  = bus_we && (bus_addr == ADDR_W'(OFS_IEN));
    en_rise = wr_ctrl && bus_wdata[CB_EN] && !ctrl_q[CB_EN];
    ld_req  = wr_kick || en_rise;
    go      = ctrl_q[CB_EN] && !stalled;
    exp_irq = expire && ctrl_q[CB_MODE];
    pulse_d = expire && !ctrl_q[CB_MODE] && !pulse_q;
  end

  wdog_stall #(.N(NUM_STALL)) u_stall (
    .stall_in ({stall_dbg, stall_week, stall_hib}),
    .stall_en (ctrl_q[CB_STALL0 +: NUM_STALL]),
    .stalled  (stalled)
  );

  wdog_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .soft_rst (pulse_q),
    .wr_load  (wr_load),
    .wr_ctrl  (wr_ctrl),
    .wr_sts   (wr_sts),
    .wr_ien   (wr_ien),
    .wdata    (bus_wdata),
    .exp_irq  (exp_irq),
    .load_q   (load_q),
    .ctrl_q   (ctrl_q),
    .sts_q    (sts_q),
    .ien_q    (ien_q)
  );

  wdog_count #(.CNT_W(CNT_W), .RST_VAL(LOAD_RST)) u_count (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .soft_rst (pulse_q),
    .go       (go),
    .tick     (tick),
    .ld_req   (ld_req),
    .mode_irq (ctrl_q[CB_MODE]),
    .ld_val   (load_q),
    .cnt      (cnt),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) pulse_q <= 1'b0;
    else          pulse_q <= pulse_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_LOAD))      bus_rdata = DATA_W'(load_q);
    else if (bus_addr == ADDR_W'(OFS_CTRL)) bus_rdata = ctrl_q;
    else if (bus_addr == ADDR_W'(OFS_CNT))  bus_rdata = DATA_W'(cnt);
    else if (bus_addr == ADDR_W'(OFS_STS))  bus_rdata = DATA_W'(sts_q);
    else if (bus_addr == ADDR_W'(OFS_IEN))  bus_rdata = DATA_W'(ien_q);
  end

  assign irq      = sts_q & ien_q;
  assign chip_rst = pulse_q;
endmodule

// File: rtl/wdog_twostage_chk.sv
module wdog_twostage_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              tick,
  input logic              go,
  input logic              chip_rst,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  load_q,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              sts_q,
  input logic              ien_q
);
  import wdog_pkg::*;

  // R7
  rst_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |=> !chip_rst);

  // R7
  rst_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |=> (load_q == LOAD_RST && ctrl_q == '0 && !sts_q && !ien_q && cnt == LOAD_RST));

  // R4
  idle_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CB_EN] && !chip_rst) |=> !chip_rst);

  // R4
  idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CB_EN] && !bus_we && !chip_rst) |=> $stable(cnt));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && tick && cnt > CNT_W'(1) && !bus_we && !chip_rst) |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R5
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CB_EN] && !go && !bus_we && !chip_rst) |=> $stable(cnt));

  // R6
  kick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFS_KICK) && !chip_rst) |=> (cnt == $past(load_q) && !chip_rst));

  // R8
  irq_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && tick && cnt == CNT_W'(1) && ctrl_q[CB_MODE] && !bus_we && !chip_rst)
      |=> (!ctrl_q[CB_MODE] && sts_q && cnt == $past(load_q) && !chip_rst));
endmodule

bind wdog_twostage wdog_twostage_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(wdog_pkg::CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_i_n),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .tick     (tick),
  .go       (go),
  .chip_rst (chip_rst),
  .cnt      (cnt),
  .load_q   (load_q),
  .ctrl_q   (ctrl_q),
  .sts_q    (sts_q),
  .ien_q    (ien_q)
);

// File: tb/wdog_twostage_bench.sv
module wdog_twostage_bench;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_we;
  logic [DATA_W-1:0] bus_wdata;
  logic [DATA_W-1:0] bus_rdata;
  logic              tick, stall_hib, stall_week, stall_dbg;
  logic              irq, chip_rst;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done   = 1'b0;

  always #4ns clk = ~clk;

  wdog_twostage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wdog_twostage (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick(tick),
    .stall_hib(stall_hib), .stall_week(stall_week), .stall_dbg(stall_dbg),
    .irq(irq), .chip_rst(chip_rst)
  );

  always @(posedge clk) if (chip_rst === 1'b1) pulses++;

  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_TK = 2'd2;
  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VECS [NV] = '{
    '{OP_RD, 8'h00, 32'h0,        32'hFFFF, 4'd1},  // R1 reload reset value
    '{OP_RD, 8'h04, 32'h0,        32'h0,    4'd1},  // R1 control
    '{OP_RD, 8'h0C, 32'h0,        32'hFFFF, 4'd1},  // R1 count
    '{OP_RD, 8'h10, 32'h0,        32'h0,    4'd1},  // R1 status
    '{OP_RD, 8'h14, 32'h0,        32'h0,    4'd1},  // R1 irq enable
    '{OP_WR, 8'h04, 32'hFFFFFFFF, 32'h0,    4'd2},
    '{OP_RD, 8'h04, 32'h0,        32'h21D,  4'd2},  // R2 mask
    '{OP_WR, 8'h04, 32'h0,        32'h0,    4'd2},
    '{OP_WR, 8'h0C, 32'h1234,     32'h0,    4'd2},
    '{OP_RD, 8'h0C, 32'h0,        32'hFFFF, 4'd2},  // R2 count read-only
    '{OP_WR, 8'h00, 32'hABCD0005, 32'h0,    4'd2},
    '{OP_RD, 8'h00, 32'h0,        32'h5,    4'd2},  // R2 16-bit reload
    '{OP_WR, 8'h04, 32'h1,        32'h0,    4'd3},
    '{OP_RD, 8'h0C, 32'h0,        32'h5,    4'd3},  // R3 enable loads
    '{OP_TK, 8'h00, 32'd2,        32'h0,    4'd3},
    '{OP_RD, 8'h0C, 32'h0,        32'h3,    4'd3},  // R3 step per tick
    '{OP_WR, 8'h04, 32'h0,        32'h0,    4'd4},
    '{OP_TK, 8'h00, 32'd3,        32'h0,    4'd4},
    '{OP_RD, 8'h0C, 32'h0,        32'h3,    4'd4},  // R4 frozen while off
    '{OP_WR, 8'h04, 32'h1,        32'h0,    4'd3},
    '{OP_TK, 8'h00, 32'd1,        32'h0,    4'd3},
    '{OP_RD, 8'h0C, 32'h0,        32'h4,    4'd3},  // R3 re-enable reloads
    '{OP_WR, 8'h08, 32'hAA,       32'h0,    4'd6},
    '{OP_RD, 8'h0C, 32'h0,        32'h5,    4'd6},  // R6 kick
    '{OP_WR, 8'h14, 32'h1,        32'h0,    4'd9},
    '{OP_WR, 8'h04, 32'h201,      32'h0,    4'd8},
    '{OP_TK, 8'h00, 32'd5,        32'h0,    4'd8},
    '{OP_RD, 8'h04, 32'h0,        32'h1,    4'd8},  // R8 mode self-clears
    '{OP_RD, 8'h10, 32'h0,        32'h1,    4'd8},  // R8 event flagged
    '{OP_RD, 8'h0C, 32'h0,        32'h5,    4'd8},  // R8 reloaded
    '{OP_WR, 8'h10, 32'h1,        32'h0,    4'd9},
    '{OP_RD, 8'h10, 32'h0,        32'h0,    4'd9}   // R9 write-one-clear
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1ns;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    tick = 1'b0; stall_hib = 1'b0; stall_week = 1'b0; stall_dbg = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1ns;
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 chip_rst", {31'b0, chip_rst}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      case (VECS[v].op)
        OP_WR: wr(VECS[v].addr, VECS[v].data);
        OP_RD: rd(VECS[v].addr, VECS[v].exp, $sformatf("R%0d vec %0d", VECS[v].req, v));
        default: ticks(int'(VECS[v].data));
      endcase
    end

    // R9 and first stage of R11: interrupt, no reset
    wr(8'h04, 32'h201);
    ticks(5);
    #1ns;
    chk("R9 irq set", {31'b0, irq}, 32'h1);
    chk("R11 no reset on first expiry", pulses, 0);
    wr(8'h14, 32'h0);
    #1ns; chk("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(8'h14, 32'h1);
    #1ns; chk("R9 irq unmasked", {31'b0, irq}, 32'h1);
    wr(8'h10, 32'h1);
    #1ns; chk("R9 irq cleared", {31'b0, irq}, 32'h0);

    // R5 stall sources (ctrl now enable only, count 5)
    wr(8'h04, 32'h1D);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      stall_hib = (k == 0); stall_week = (k == 1); stall_dbg = (k == 2);
      ticks(1);
      rd(8'h0C, 32'h5, $sformatf("R5 stall source %0d holds", k));
    end
    wr(8'h04, 32'h1);
    @(negedge clk); stall_hib = 1'b1; stall_week = 1'b1; stall_dbg = 1'b1;
    ticks(1);
    rd(8'h0C, 32'h4, "R5 stall without enable ignored");
    @(negedge clk); stall_hib = 1'b0; stall_week = 1'b0; stall_dbg = 1'b0;

    // R10 kick on the expiry tick (reset mode)
    ticks(3);
    rd(8'h0C, 32'h1, "R10 count at one");
    @(negedge clk);
    bus_addr = 8'h08; bus_wdata = 32'h0; bus_we = 1'b1; tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick = 1'b0;
    #1ns; chk("R10 no reset pulse", {31'b0, chip_rst}, 32'h0);
    rd(8'h0C, 32'h5, "R10 kick reloaded");
    chk("R10 reset count", pulses, 0);

    // R11 full two-stage sequence and R7 reset pulse
    wr(8'h00, 32'h2);
    wr(8'h04, 32'h201);
    wr(8'h08, 32'h0);
    ticks(2);
    #1ns; chk("R11 first expiry no reset", {31'b0, chip_rst}, 32'h0);
    rd(8'h04, 32'h1, "R11 mode cleared after first expiry");
    rd(8'h0C, 32'h2, "R8 reload after expiry");
    ticks(2);
    #1ns; chk("R7 reset pulse high", {31'b0, chip_rst}, 32'h1);
    @(negedge clk);
    #1ns; chk("R7 reset pulse one cycle", {31'b0, chip_rst}, 32'h0);
    chk("R11 one reset pulse", pulses, 1);
    rd(8'h00, 32'hFFFF, "R7 reload restored");
    rd(8'h04, 32'h0, "R7 control restored");
    rd(8'h10, 32'h0, "R7 status restored");
    rd(8'h14, 32'h0, "R7 irq enable restored");
    rd(8'h0C, 32'hFFFF, "R7 count restored");

    // R4 no expiry while disabled
    wr(8'h00, 32'h1);
    ticks(10);
    chk("R4 no reset while disabled", pulses, 1);
    rd(8'h0C, 32'hFFFF, "R4 count frozen");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule